// File: doc/BRIEF.md
# DRAM Page-Mode Cycle Sequencer

This block turns single memory requests into RAS/CAS strobe sequences for a set of DRAM banks, and puts the row and column address onto a shared set of DRAM address pins at the right times. Each bank has its own static configuration: a page policy, a data port width and an internal page size. Each request gives a bank, a byte address and an operand size. From these the block works out how many data beats the operand needs. It also decides whether each beat needs a full row cycle followed by a column cycle, or only a column cycle inside a row that is already open.

Three page policies are supported. The normal policy opens and closes a row for every beat. The fast-page policy keeps a row open after a transfer, so a later hit costs only a column cycle. The burst policy opens one row per operand and runs all of the operand's beats as column cycles, then closes the row. One timing set, shared by all banks, gives the precharge, RAS-to-CAS and CAS widths in clock cycles. A new request is accepted only while the block is idle.

Top module: `dram_seq`

## Requirements
- R1: After reset, every RAS and CAS line is high (negated), `busy_o` is low, `da_o` is zero, and `beat_o` and `done_o` are low.
- R2: A full row cycle runs in three steps. First the bank's RAS is high for the precharge count, with `da_o` at zero. Then RAS is low with `da_o` holding the row for the RAS-to-CAS count. Then RAS and CAS are both low with `da_o` holding the column for the CAS count. CAS is never low unless some RAS is low.
- R3: Fast-page mode (mode code 01) leaves the row open (RAS low) after a transfer. A later request to the same bank and row starts its CAS in the first cycle after it is accepted, with no precharge or row step.
- R4: In fast-page mode, a request to a different row of an open bank first negates that bank's RAS for the precharge count, then runs a full row cycle.
- R5: An open page whose bank has had no transfer for IDLE_TO cycles after its last CAS cycle is closed (RAS negated). A request accepted on the closing cycle, or later, runs a full row cycle.
- R6: Burst mode (mode code 10 or 11) behaves like normal mode when the operand needs one beat. When it needs several beats, it opens the row once and runs each following beat as one CAS-high gap cycle plus a CAS step, then closes the row. Every beat pulse is followed by a cycle with CAS high.
- R7: An operand wider than the port is split into 2 or 4 beats in ascending address order, and `beat_addr_o` gives each beat's byte address. Normal mode (code 00) runs a full row cycle for every beat.
- R8: Port code 01 means 8 bits, 10 means 16 bits, and 00 or 11 means 32 bits. Page code 00, 01 or 10 means 512 B, 1 KB or 2 KB, and 11 means 2 KB. Size code 00, 01 or 10 means byte, half-word or word, and 11 means word. The column is (address >> log2(port bytes)) modulo 2^(log2(page bytes) − log2(port bytes)). The row is address >> log2(page bytes), cut to the DA_W low bits.
- R9: The timing counts apply to every bank, and a count of zero behaves as one.
- R10: `done_o` pulses together with the last beat's `beat_o`. `busy_o` is high from the cycle after acceptance until that last pulse. A request presented while `busy_o` is high is ignored.
- R11: Each bank keeps its open page on its own. A transfer to one bank leaves another bank's open RAS low and its row still available for a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when idle |
| req_bank_i | input | BANK_W | Target bank |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | Operand size code |
| cfg_mode_i | input | 2*NBANK | Page policy per bank, 2 bits each |
| cfg_port_i | input | 2*NBANK | Port width code per bank |
| cfg_page_i | input | 2*NBANK | Page size code per bank |
| t_rp_i | input | TMR_W | Precharge cycles |
| t_rcd_i | input | TMR_W | RAS-to-CAS cycles |
| t_cas_i | input | TMR_W | CAS low cycles |
| busy_o | output | 1 | Transfer in progress |
| ras_n_o | output | NBANK | Row strobe per bank, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| da_o | output | DA_W | Multiplexed DRAM address |
| beat_o | output | 1 | Last cycle of a beat's CAS step |
| beat_addr_o | output | ADDR_W | Byte address of the current beat |
| done_o | output | 1 | Last beat of the transfer |

## Verification
The bench probes the idle-timeout boundary with requests one cycle before and exactly on the closing cycle. A counter that is off by one there would either hit a row that has already closed, with CAS and no row cycle, or waste a precharge on a row that is still open. A row miss in fast-page mode would show a missing precharge if the open flag were not cleared. Multi-beat operands in each policy expose wrong beat order, a missing CAS-high gap, or a row re-opened inside a burst. Zero timing counts, a request ignored while busy, and another bank's page staying open during a transfer each show up as a strobe or address mismatch in the per-cycle comparison.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_ROW, ST_CAS, ST_GAP} seq_state_e;

  localparam logic [1:0] MODE_NORMAL = 2'b00;
  localparam logic [1:0] MODE_FAST   = 2'b01;

  // log2 of port width in bytes
  function automatic logic [1:0] port_shift(input logic [1:0] code);
    case (code)
      2'b01:   return 2'd0;
      2'b10:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [1:0] size_shift(input logic [1:0] code);
    return (code == 2'b11) ? 2'd2 : code;
  endfunction

  // page bytes = 512 << page_step
  function automatic logic [1:0] page_step(input logic [1:0] code);
    return (code == 2'b11) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/dram_seq_geom.sv
module dram_seq_geom import dram_seq_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int DA_W   = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [1:0]        port_i,
  input  logic [1:0]        page_i,
  output logic [DA_W-1:0]   row_o,
  output logic [1:0]        ps_o,
  output logic [3:0]        cb_o,
  output logic [1:0]        nb_m1_o
);
  logic [1:0]        ps, os, pg;
  logic [ADDR_W-1:0] row_full;
  logic [2:0]        nb;

  assign ps       = port_shift(port_i);
  assign os       = size_shift(size_i);
  assign pg       = page_step(page_i);
  assign row_full = addr_i >> (4'd9 + {2'b00, pg});
  assign row_o    = row_full[DA_W-1:0];
  assign ps_o     = ps;
  assign cb_o     = 4'd9 + {2'b00, pg} - {2'b00, ps};
  assign nb       = (os > ps) ? (3'd1 << (os - ps)) : 3'd1;
  assign nb_m1_o  = 2'(nb - 3'd1);
endmodule

// File: rtl/dram_seq_bank_track.sv
module dram_seq_bank_track #(
  parameter int NBANK   = 2,
  parameter int DA_W    = 12,
  parameter int IDLE_TO = 16,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int IW     = $clog2(IDLE_TO + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [BANK_W-1:0] cur_bank_i,
  input  logic              set_i,
  input  logic [DA_W-1:0]   set_row_i,
  input  logic              clr_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [DA_W-1:0]   req_row_i,
  output logic              hit_o,
  output logic [NBANK-1:0]  open_o
);
  logic [NBANK-1:0] hit_b;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic            open_q;
    logic [DA_W-1:0] row_q;
    logic [IW-1:0]   idle_q;
    logic            in_use, expire;

    assign in_use = busy_i && (cur_bank_i == BANK_W'(b));
    assign expire = open_q && !in_use && (idle_q == IW'(IDLE_TO - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
        row_q  <= '0;
        idle_q <= '0;
      end else begin
        if (set_i && in_use) begin
          open_q <= 1'b1;
          row_q  <= set_row_i;
        end else if ((clr_i && req_bank_i == BANK_W'(b)) || expire) begin
          open_q <= 1'b0;
        end
        if (!open_q || in_use || expire) idle_q <= '0;
        else                             idle_q <= idle_q + IW'(1);
      end
    end

    assign open_o[b] = open_q;
    assign hit_b[b]  = open_q && !expire && (row_q == req_row_i);
  end

  assign hit_o = hit_b[req_bank_i];
endmodule

// File: rtl/dram_seq.sv
module dram_seq import dram_seq_pkg::*; #(
  parameter int NBANK   = 2,
  parameter int ADDR_W  = 24,
  parameter int DA_W    = 12,
  parameter int TMR_W   = 4,
  parameter int IDLE_TO = 16,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [BANK_W-1:0]  req_bank_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic [2*NBANK-1:0] cfg_mode_i,
  input  logic [2*NBANK-1:0] cfg_port_i,
  input  logic [2*NBANK-1:0] cfg_page_i,
  input  logic [TMR_W-1:0]   t_rp_i,
  input  logic [TMR_W-1:0]   t_rcd_i,
  input  logic [TMR_W-1:0]   t_cas_i,
  output logic               busy_o,
  output logic [NBANK-1:0]   ras_n_o,
  output logic               cas_n_o,
  output logic [DA_W-1:0]    da_o,
  output logic               beat_o,
  output logic [ADDR_W-1:0]  beat_addr_o,
  output logic               done_o
);
  seq_state_e        state_q;
  logic [TMR_W-1:0]  cnt_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        ps_q, nb_m1_q, beat_q;
  logic [3:0]        cb_q;
  logic [DA_W-1:0]   row_q;
  logic              every_row_q, keep_q;

  logic [1:0]        sel_mode, sel_port, sel_page;
  logic [DA_W-1:0]   g_row;
  logic [1:0]        g_ps, g_nb_m1;
  logic [3:0]        g_cb;
  logic              trk_hit, req_fast, req_hit, acc, last_cas, last_beat, busy, act;
  logic [NBANK-1:0]  trk_open;

  assign sel_mode = cfg_mode_i[{req_bank_i, 1'b0} +: 2];
  assign sel_port = cfg_port_i[{req_bank_i, 1'b0} +: 2];
  assign sel_page = cfg_page_i[{req_bank_i, 1'b0} +: 2];

  dram_seq_geom #(.ADDR_W(ADDR_W), .DA_W(DA_W)) u_geom (
    .addr_i (req_addr_i),
    .size_i (req_size_i),
    .port_i (sel_port),
    .page_i (sel_page),
    .row_o  (g_row),
    .ps_o   (g_ps),
    .cb_o   (g_cb),
    .nb_m1_o(g_nb_m1)
  );

  assign busy      = state_q != ST_IDLE;
  assign acc       = !busy && req_i;
  assign req_fast  = sel_mode == MODE_FAST;
  assign req_hit   = req_fast && trk_hit;
  assign last_cas  = (state_q == ST_CAS) && (cnt_q == TMR_W'(1));
  assign last_beat = beat_q == nb_m1_q;

  dram_seq_bank_track #(.NBANK(NBANK), .DA_W(DA_W), .IDLE_TO(IDLE_TO)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .cur_bank_i(bank_q),
    .set_i     (last_cas && last_beat && keep_q),
    .set_row_i (row_q),
    .clr_i     (acc && !req_hit),
    .req_bank_i(req_bank_i),
    .req_row_i (g_row),
    .hit_o     (trk_hit),
    .open_o    (trk_open)
  );

  function automatic logic [TMR_W-1:0] ld(input logic [TMR_W-1:0] t);
    return (t == '0) ? TMR_W'(1) : t;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      bank_q      <= '0;
      base_q      <= '0;
      ps_q        <= '0;
      nb_m1_q     <= '0;
      beat_q      <= '0;
      cb_q        <= '0;
      row_q       <= '0;
      every_row_q <= 1'b0;
      keep_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_i) begin
          bank_q      <= req_bank_i;
          base_q      <= req_addr_i;
          ps_q        <= g_ps;
          nb_m1_q     <= g_nb_m1;
          cb_q        <= g_cb;
          row_q       <= g_row;
          beat_q      <= '0;
          every_row_q <= sel_mode == MODE_NORMAL;
          keep_q      <= req_fast;
          if (req_hit) begin
            state_q <= ST_CAS;
            cnt_q   <= ld(t_cas_i);
          end else begin
            state_q <= ST_PRE;
            cnt_q   <= ld(t_rp_i);
          end
        end
        ST_PRE: if (cnt_q != TMR_W'(1)) cnt_q <= cnt_q - TMR_W'(1);
                else begin state_q <= ST_ROW; cnt_q <= ld(t_rcd_i); end
        ST_ROW: if (cnt_q != TMR_W'(1)) cnt_q <= cnt_q - TMR_W'(1);
                else begin state_q <= ST_CAS; cnt_q <= ld(t_cas_i); end
        ST_CAS: if (cnt_q != TMR_W'(1)) cnt_q <= cnt_q - TMR_W'(1);
                else if (last_beat) state_q <= ST_IDLE;
                else begin
                  beat_q <= beat_q + 2'd1;
                  if (every_row_q) begin state_q <= ST_PRE; cnt_q <= ld(t_rp_i); end
                  else              state_q <= ST_GAP;
                end
        ST_GAP: begin state_q <= ST_CAS; cnt_q <= ld(t_cas_i); end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [ADDR_W-1:0] beat_addr, col_mask, col_full;
  assign beat_addr = base_q + (ADDR_W'(beat_q) << ps_q);
  assign col_mask  = (ADDR_W'(1) << cb_q) - ADDR_W'(1);
  assign col_full  = (beat_addr >> ps_q) & col_mask;

  assign act = (state_q == ST_ROW) || (state_q == ST_CAS) || (state_q == ST_GAP);

  for (genvar b = 0; b < NBANK; b++) begin : g_ras
    logic mine;
    assign mine       = busy && (bank_q == BANK_W'(b));
    assign ras_n_o[b] = !(mine ? act : trk_open[b]);
  end

  always_comb begin
    case (state_q)
      ST_ROW:         da_o = row_q;
      ST_CAS, ST_GAP: da_o = col_full[DA_W-1:0];
      default:        da_o = '0;
    endcase
  end

  assign cas_n_o     = state_q != ST_CAS;
  assign busy_o      = busy;
  assign beat_o      = last_cas;
  assign done_o      = last_cas && last_beat;
  assign beat_addr_o = beat_addr;
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int NBANK = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic [NBANK-1:0] ras_n_o,
  input logic             cas_n_o,
  input logic             beat_o,
  input logic             done_o
);
  // R2
  cas_needs_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_o |-> (ras_n_o != '1));
  // R10
  done_with_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> beat_o);
  // R10
  idle_no_cas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cas_n_o);
  // R6
  cas_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o |=> cas_n_o);
endmodule

bind dram_seq dram_seq_chk #(.NBANK(NBANK)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_o (busy_o),
  .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o),
  .beat_o (beat_o),
  .done_o (done_o)
);

// File: tb/tb_dram_seq.sv
module tb_dram_seq;
  localparam int NBANK = 2, ADDR_W = 24, DA_W = 12, TMR_W = 4, IDLE_TO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic               req = 1'b0;
  logic [0:0]         req_bank = '0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [1:0]         req_size = '0;
  logic [2*NBANK-1:0] cfg_mode = '0, cfg_port = '0, cfg_page = '0;
  logic [TMR_W-1:0]   t_rp = 4'd2, t_rcd = 4'd2, t_cas = 4'd2;
  logic               busy, cas_n, beat, done;
  logic [NBANK-1:0]   ras_n;
  logic [DA_W-1:0]    da;
  logic [ADDR_W-1:0]  beat_addr;

  dram_seq #(.NBANK(NBANK), .ADDR_W(ADDR_W), .DA_W(DA_W), .TMR_W(TMR_W), .IDLE_TO(IDLE_TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_bank_i(req_bank), .req_addr_i(req_addr),
    .req_size_i(req_size), .cfg_mode_i(cfg_mode), .cfg_port_i(cfg_port), .cfg_page_i(cfg_page),
    .t_rp_i(t_rp), .t_rcd_i(t_rcd), .t_cas_i(t_cas), .busy_o(busy), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .da_o(da), .beat_o(beat), .beat_addr_o(beat_addr), .done_o(done)
  );

  int errors = 0, checks = 0;
  string tag = "R1";

  // expected per-cycle trace of the active transfer
  bit q_ras[$], q_cas[$], q_beat[$], q_done[$];
  int q_da[$], q_ba[$];
  bit m_busy = 0, m_keep = 0;
  int m_bank = 0, m_cur_row = 0;
  bit m_open[NBANK];
  int m_row[NBANK], m_idle[NBANK];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit r, input bit c, input int d, input bit bt, input bit dn, input int ba);
    q_ras.push_back(r); q_cas.push_back(c); q_da.push_back(d);
    q_beat.push_back(bt); q_done.push_back(dn); q_ba.push_back(ba);
  endtask

  function automatic int pshift(input int b);
    int c = int'(cfg_port[b*2 +: 2]);
    return (c == 1) ? 0 : (c == 2) ? 1 : 2;
  endfunction
  function automatic int pstep(input int b);
    int c = int'(cfg_page[b*2 +: 2]);
    return (c == 3) ? 2 : c;
  endfunction
  function automatic int row_of(input int b, input int a);
    return (a >> (9 + pstep(b))) & ((1 << DA_W) - 1);
  endfunction
  function automatic int ld(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic build(input int b, input int a, input int sz, input bit hit);
    int ps = pshift(b);
    int os = (sz == 3) ? 2 : sz;
    int cb = 9 + pstep(b) - ps;
    int nb = (os > ps) ? (1 << (os - ps)) : 1;
    int mode = int'(cfg_mode[b*2 +: 2]);
    int row = row_of(b, a);
    for (int k = 0; k < nb; k++) begin
      int ba = (a + (k << ps)) & ((1 << ADDR_W) - 1);
      int col = (ba >> ps) & ((1 << cb) - 1);
      if ((k == 0 && !hit) || (k > 0 && mode == 0)) begin
        repeat (ld(int'(t_rp)))  push(0, 0, 0, 0, 0, ba);
        repeat (ld(int'(t_rcd))) push(1, 0, row, 0, 0, ba);
      end else if (k > 0) push(1, 0, col, 0, 0, ba);
      for (int c = 0; c < ld(int'(t_cas)); c++)
        push(1, 1, col, c == ld(int'(t_cas)) - 1, (c == ld(int'(t_cas)) - 1) && (k == nb - 1), ba);
    end
  endtask

  task automatic model_edge();
    bit expire[NBANK];
    for (int b = 0; b < NBANK; b++) begin
      bit in_use = m_busy && m_bank == b;
      expire[b] = m_open[b] && !in_use && m_idle[b] == IDLE_TO - 1;
      if (!m_open[b] || in_use || expire[b]) m_idle[b] = 0; else m_idle[b]++;
      if (expire[b]) m_open[b] = 0;
    end
    if (m_busy) begin
      void'(q_ras.pop_front()); void'(q_cas.pop_front()); void'(q_da.pop_front());
      void'(q_beat.pop_front()); void'(q_done.pop_front()); void'(q_ba.pop_front());
      if (q_ras.size() == 0) begin
        m_busy = 0;
        if (m_keep) begin m_open[m_bank] = 1; m_row[m_bank] = m_cur_row; end
      end
    end else if (req) begin
      int b = int'(req_bank);
      int a = int'(req_addr);
      bit fast = cfg_mode[b*2 +: 2] == 2'b01;
      bit hit = fast && m_open[b] && m_row[b] == row_of(b, a);
      if (!hit) m_open[b] = 0;
      build(b, a, int'(req_size), hit);
      m_busy = 1; m_bank = b; m_keep = fast; m_cur_row = row_of(b, a);
    end
  endtask

  task automatic compare();
    for (int b = 0; b < NBANK; b++) begin
      bit low = (m_busy && m_bank == b) ? q_ras[0] : m_open[b];
      chk(ras_n[b] == !low, $sformatf("ras_n[%0d]", b), int'(ras_n[b]), int'(!low));
    end
    chk(busy == m_busy, "busy", int'(busy), int'(m_busy));
    chk(cas_n == !(m_busy && q_cas[0]), "cas_n", int'(cas_n), int'(!(m_busy && q_cas[0])));
    chk(int'(da) == (m_busy ? q_da[0] : 0), "da", int'(da), m_busy ? q_da[0] : 0);
    chk(beat == (m_busy && q_beat[0]), "beat", int'(beat), int'(m_busy && q_beat[0]));
    chk(done == (m_busy && q_done[0]), "done", int'(done), int'(m_busy && q_done[0]));
    if (m_busy && q_beat[0])
      chk(int'(beat_addr) == q_ba[0], "beat_addr", int'(beat_addr), q_ba[0]);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic access(input int b, input int a, input int sz);
    req = 1; req_bank = 1'(b); req_addr = ADDR_W'(a); req_size = 2'(sz);
    step();
    req = 0;
    while (m_busy) step();
  endtask

  task automatic set_bank(input int b, input int mode, input int port, input int page);
    cfg_mode[b*2 +: 2] = 2'(mode);
    cfg_port[b*2 +: 2] = 2'(port);
    cfg_page[b*2 +: 2] = 2'(page);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R10 act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < NBANK; b++) begin m_open[b] = 0; m_row[b] = 0; m_idle[b] = 0; end
    set_bank(0, 0, 1, 0);
    set_bank(1, 1, 2, 1);
    repeat (2) @(negedge clk);
    // R1 reset state
    tag = "R1";
    chk(ras_n == '1, "ras_n", int'(ras_n), 3);
    chk(cas_n == 1'b1, "cas_n", int'(cas_n), 1);
    chk(!busy && !beat && !done, "busy/beat/done", int'({busy, beat, done}), 0);
    chk(da == '0, "da", int'(da), 0);
    rst_n = 1'b1;
    step();

    tag = "R2";  access(0, 24'h001234, 0);   // normal byte, 8-bit port, 512 B page (R8)
    tag = "R7";  access(0, 24'h000404, 2);   // word on 8-bit port, four row cycles
    tag = "R3";  access(1, 24'h123456, 1);   // fast miss
                 access(1, 24'h123500, 1);   // same row: hit
                 access(1, 24'h123600, 2);   // two beats in open page
    tag = "R4";  access(1, 24'h200000, 1);   // different row
    tag = "R11"; access(0, 24'h000010, 0);   // other bank while bank 1 is open
                 access(1, 24'h200010, 1);   // still a hit
    tag = "R5";  repeat (IDLE_TO - 2) step(); access(1, 24'h200020, 1);   // just before close: hit
                 repeat (IDLE_TO - 1) step(); access(1, 24'h200030, 1);   // on close: miss
                 repeat (IDLE_TO + 4) step(); access(1, 24'h200040, 1);   // long after
    tag = "R6";  set_bank(0, 2, 1, 0);
                 access(0, 24'h000100, 0);   // single beat: normal
                 access(0, 24'h000200, 2);   // four beats, one row
                 set_bank(0, 3, 2, 1);
                 access(0, 24'h000A02, 2);   // code 11 burst, two beats
    tag = "R8";  set_bank(0, 0, 0, 2);
                 access(0, 24'hABCDEC, 2);   // 32-bit port, 2 KB page
                 set_bank(0, 0, 2, 3);
                 access(0, 24'h3FFFFF, 0);   // 16-bit port, page code 11
                 set_bank(0, 0, 3, 1);
                 access(0, 24'h0F0F0C, 3);   // port code 11, size code 11
    tag = "R9";  t_rp = 4'd0; t_rcd = 4'd3; t_cas = 4'd0;
                 access(1, 24'h300000, 2);
                 access(1, 24'h300004, 0);
                 set_bank(0, 0, 1, 0);
                 access(0, 24'h000033, 1);
                 t_rp = 4'd3; t_rcd = 4'd1; t_cas = 4'd3;
                 access(0, 24'h000044, 1);
    tag = "R10"; req = 1; req_bank = 1'b0; req_addr = 24'h000050; req_size = 2'd2;
                 step();
                 req_bank = 1'b1; req_addr = 24'h0700FF;   // ignored while busy
                 step(); step();
                 req = 0;
                 while (m_busy) step();
                 repeat (3) step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule